// File: doc/BRIEF.md
# Rotating Complex Vector Adder

This block adds two packed vectors of complex integers after turning the second operand by a quarter turn in either direction. Each vector is split into lanes of integer elements, and neighbouring lanes form complex values. Within each pair, the lower lane is the real part and the upper lane is the imaginary part. Turning the second operand swaps its real and imaginary parts and negates one of them. This replaces a plain lane-by-lane sum. The direction of the turn is picked by a single select bit.

Three selects set the shape of the operation: the turn direction, the element width (32 or 64 bits) and the vector width (128 or 64 bits). A request is taken on a valid strobe. The result appears one clock later with its own valid strobe. A shape that cannot hold a single complex pair raises a configuration-error flag instead of producing a result. No condition flags are produced.

Top module: `cplx_rot_add`

## Requirements
- R1: Within each complex pair, the lower-addressed lane is the real part and the next lane up is the imaginary part. This holds for both operands and for the result.
- R2: With `rot_sel`=0 (quarter turn forward):
  - result real = a.real − b.imag
  - result imaginary = a.imag + b.real
- R3: With `rot_sel`=1 (quarter turn back):
  - result real = a.real + b.imag
  - result imaginary = a.imag − b.real
- R4: With `esize_sel`=0 (32-bit elements) and `wide_sel`=1 (128-bit vector), two independent complex pairs are processed:
  - bits 63:0
  - bits 127:64
- R5: With `esize_sel`=1 (64-bit elements) and `wide_sel`=1, exactly one complex pair is processed:
  - real part in bits 63:0
  - imaginary part in bits 127:64
- R6: With `wide_sel`=0 (64-bit vector) and 32-bit elements, one pair is processed in bits 63:0, and result bits 127:64 are zero.
- R7: Every add and subtract wraps modulo 2^element width. There is no saturation, and no carry crosses into a neighbouring lane.
- R8: With `wide_sel`=0 and `esize_sel`=1, the output has `cfg_err`=1 and a result of all zeros. Every legal shape gives `cfg_err`=0.
- R9: A request taken with `in_valid`=1 appears on `res_vec`/`cfg_err` with `out_valid`=1 on the next clock. A cycle with `in_valid`=0 gives `out_valid`=0 on the next clock, and `res_vec`/`cfg_err` keep their previous values.
- R10: A synchronous active-high reset drives `out_valid`, `cfg_err` and `res_vec` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands and selects are taken when high |
| a_vec | input | 128 | First complex vector operand |
| b_vec | input | 128 | Second complex vector operand, turned before the add |
| rot_sel | input | 1 | 0: quarter turn forward, 1: quarter turn back |
| esize_sel | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| wide_sel | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| res_vec | output | 128 | Result vector |
| out_valid | output | 1 | Result strobe, one clock after the request |
| cfg_err | output | 1 | Illegal shape flag for the presented result |

## Verification
Faults in this block show up on the result vector, in the very next cycle after the request.

- A swapped real/imaginary pick or an inverted turn direction puts the wrong sign or the wrong part in a lane.
- A wrong pair count or a missing upper-half clear leaves stray bits above the active width.
- A carry leaking across lanes breaks the wraparound edge patterns.

The sweep covers every shape and both turn directions. It uses edge values and pseudo-random values, so each such fault shows up on the first affected request.

// File: rtl/cplx_rot_add.sv
module cplx_rot_add #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] a_vec,
  input  logic [VEC_W-1:0] b_vec,
  input  logic             rot_sel,
  input  logic             esize_sel,
  input  logic             wide_sel,
  output logic [VEC_W-1:0] res_vec,
  output logic             out_valid,
  output logic             cfg_err
);
  localparam int HALF_W = VEC_W / 2;
  localparam int P32    = VEC_W / 64;
  localparam int P64    = VEC_W / 128;

  logic [VEC_W-1:0] sum32, sum64, pick, nxt;
  logic             bad;

  for (genvar k = 0; k < P32; k++) begin : g_p32
    logic [31:0] nr, ni, mr, mi;
    assign nr = a_vec[64*k +: 32];
    assign ni = a_vec[64*k+32 +: 32];
    assign mr = b_vec[64*k +: 32];
    assign mi = b_vec[64*k+32 +: 32];
    assign sum32[64*k +: 32]    = rot_sel ? nr + mi : nr - mi;
    assign sum32[64*k+32 +: 32] = rot_sel ? ni - mr : ni + mr;
  end

  for (genvar k = 0; k < P64; k++) begin : g_p64
    logic [63:0] nr, ni, mr, mi;
    assign nr = a_vec[128*k +: 64];
    assign ni = a_vec[128*k+64 +: 64];
    assign mr = b_vec[128*k +: 64];
    assign mi = b_vec[128*k+64 +: 64];
    assign sum64[128*k +: 64]    = rot_sel ? nr + mi : nr - mi;
    assign sum64[128*k+64 +: 64] = rot_sel ? ni - mr : ni + mr;
  end

  assign bad  = !wide_sel && esize_sel;
  assign pick = esize_sel ? sum64 : sum32;
  assign nxt  = bad ? '0 : (wide_sel ? pick : {{HALF_W{1'b0}}, pick[HALF_W-1:0]});

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cfg_err   <= 1'b0;
      res_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_vec <= nxt;
        cfg_err <= bad;
      end
    end
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R9
  idle_lat_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(res_vec) && $stable(cfg_err));
  // R8
  err_flag_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> cfg_err == $past(!wide_sel && esize_sel));
  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && cfg_err |-> res_vec == '0);
  // R6
  narrow_top_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !wide_sel |=> res_vec[VEC_W-1:HALF_W] == '0);
  // R10
  reset_clr_chk: assert property (@(posedge clk)
    rst |=> !out_valid && !cfg_err && res_vec == '0);
endmodule

// File: tb/test_cplx_rot_add.sv
module test_cplx_rot_add;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [127:0] a_vec = '0, b_vec = '0;
  logic rot_sel = 0, esize_sel = 0, wide_sel = 1;
  logic [127:0] res_vec;
  logic out_valid, cfg_err;
  int errors = 0, checks = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #2 clk = ~clk;

  cplx_rot_add #(.VEC_W(128)) i_cplx_rot_add (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_vec(a_vec), .b_vec(b_vec),
    .rot_sel(rot_sel), .esize_sel(esize_sel), .wide_sel(wide_sel),
    .res_vec(res_vec), .out_valid(out_valid), .cfg_err(cfg_err));

  function automatic logic [63:0] next_rng(input logic [63:0] s);
    logic [63:0] x = s;
    x ^= x << 13; x ^= x >> 7; x ^= x << 17;
    return x;
  endfunction

  // R1 lane roles, R2/R3 signs, R4..R6 pair counts, R7 wrap, R8 illegal shape
  function automatic logic [128:0] model(input logic r, input logic e, input logic w,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [127:0] msk, ar, ai, br, bi, rr, ri, res;
    int es, width;
    if (!w && e) return {1'b1, 128'd0};
    es    = e ? 64 : 32;
    width = w ? 128 : 64;
    msk   = e ? {64'd0, ~64'd0} : {96'd0, ~32'd0};
    res   = '0;
    for (int k = 0; k < width / (2 * es); k++) begin
      ar = (a >> (2*es*k)) & msk;  ai = (a >> (2*es*k + es)) & msk;
      br = (b >> (2*es*k)) & msk;  bi = (b >> (2*es*k + es)) & msk;
      rr = (r ? ar + bi : ar - bi) & msk;
      ri = (r ? ai - br : ai + br) & msk;
      res |= (rr << (2*es*k)) | (ri << (2*es*k + es));
    end
    return {1'b0, res};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic run_one(input logic r, input logic e, input logic w,
                         input logic [127:0] a, input logic [127:0] b, input string extra);
    logic [128:0] m;
    string tag;
    m = model(r, e, w, a, b);
    tag = {r ? "R3" : "R2", "/", (!w && e) ? "R8" : (!w ? "R6" : (e ? "R5" : "R4")), extra};
    @(negedge clk);
    in_valid = 1; rot_sel = r; esize_sel = e; wide_sel = w; a_vec = a; b_vec = b;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " res"}, res_vec, m[127:0]);
    chk({tag, " err"}, {127'd0, cfg_err}, {127'd0, m[128]});
    chk({"R9 valid ", tag}, {127'd0, out_valid}, 128'd1);
  endtask

  task automatic run_all;
    logic [63:0] edges [4] = '{64'h7FFFFFFFFFFFFFFF, 64'h8000000000000000,
                               64'hFFFFFFFFFFFFFFFF, 64'h00000001FFFFFFFF};
    logic [127:0] hold_r;
    logic hold_e;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 valid", {127'd0, out_valid}, 128'd0);
    chk("R10 err", {127'd0, cfg_err}, 128'd0);
    chk("R10 res", res_vec, 128'd0);
    rst = 0;
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)  // R7 wrap at lane edges
          run_one(cfg[0], cfg[1], cfg[2], {edges[i], edges[j]}, {edges[j], edges[i]}, "/R7");
      for (int n = 0; n < 30; n++) begin
        logic [127:0] a, b;
        rng = next_rng(rng); a[63:0] = rng;  rng = next_rng(rng); a[127:64] = rng;
        rng = next_rng(rng); b[63:0] = rng;  rng = next_rng(rng); b[127:64] = rng;
        run_one(cfg[0], cfg[1], cfg[2], a, b, "/R1");
      end
    end
    // R9: idle cycle keeps result and flag, drops valid
    run_one(1'b0, 1'b0, 1'b1, {4{32'h12345678}}, {4{32'h0000FFFF}}, "/R1");
    hold_r = res_vec; hold_e = cfg_err;
    @(negedge clk);
    a_vec = ~a_vec; b_vec = ~b_vec; rot_sel = 1; wide_sel = 0; esize_sel = 1;
    @(negedge clk);
    chk("R9 idle valid", {127'd0, out_valid}, 128'd0);
    chk("R9 idle res", res_vec, hold_r);
    chk("R9 idle err", {127'd0, cfg_err}, {127'd0, hold_e});
    // R10: reset after activity
    run_one(1'b1, 1'b1, 1'b0, '1, '1, "");
    rst = 1;
    @(negedge clk);
    chk("R10 valid after", {127'd0, out_valid}, 128'd0);
    chk("R10 err after", {127'd0, cfg_err}, 128'd0);
    rst = 0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R9 watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule